// File: doc/BRIEF.md
# Split-Line Instruction Fetch Aligner

This block is the read side of an instruction cache. It returns a 16-byte window of code that starts at any byte address, even when the window runs past the end of a 32-byte line. The block divides each line into two 16-byte halves. The window always covers two consecutive halves: the half that holds the fetch address and the half after it. The block reads both halves in the same lookup cycle, through two independent tag/data array ports. When the window crosses a line boundary, the second port reads the next line. The block then shifts the joined bytes so that byte 0 of the window is the byte at the fetch address, and the bytes that follow are in ascending address order. This matters because an instruction is 1 to 15 bytes long and may cross into the next line.

The tag/data array sits outside the block and answers combinationally. For each half it returns:
- the stored tag,
- a 2-bit coherence code,
- 16 data bytes,
- one parity bit for each 8-byte group.

The cache holds code only. It has no store path, and a line is either Shared or Invalid. A miss on either port withholds the window and reports the line address that missed. A parity mismatch raises an error flag and also withholds the window.

The controller is a three-state machine:
- **IDLE**: the block is ready for a request. A request moves it to LOOKUP (transition *accept*).
- **LOOKUP**: both ports are addressed from the captured fetch address, and the results are registered. The block always moves on to RESP (transition *capture*).
- **RESP**: the result is presented for one cycle. The block always returns to IDLE (transition *release*).

Top module: `sla_fetch_aligner`

## Requirements
- R1: After reset, `fetch_rdy` is 1, and `fetch_done`, `win_vld`, `miss0`, `miss1` and `par_err` are 0.
- R2: During lookup, port 0 addresses the half that holds the fetch address. Port 1 addresses the next half, which is the first half of the next line (index + 1, wrapping) when the fetch address is in an upper half. The half address is the fetch address shifted right by 4; the index is bits 11:5 and the half select is bit 4.
- R3: Byte i of `win_data` (bits 8i+7:8i) is the byte at fetch address + i, for every byte offset 0 to 31.
- R4: A window that crosses a line boundary is produced by a single access. `fetch_done` is high for exactly one cycle, two clock edges after the edge that accepts the request.
- R5: A port hits only when its coherence code is Shared (2'b01) and its tag equals fetch line address bits 26:7. Invalid (2'b00) and every other code miss.
- R6: When either port misses, `win_vld` stays 0 and the matching `miss0`/`miss1` flag is set. `miss_line` gives the line address (fetch address bits 31:5) of port 0 if it missed, otherwise that of port 1. With no miss, `miss_line` is 0.
- R7: Parity is checked only when both ports hit. Parity bit g of a half (g = 0 or 1) must equal the XOR of bytes 8g to 8g+7 of that half. Any mismatch sets `par_err` and keeps `win_vld` at 0.
- R8: `fetch_rdy` is 0 in LOOKUP and RESP. A request or an address change in those cycles does not affect the result in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_req | input | 1 | Fetch request, taken when `fetch_rdy` is 1 |
| fetch_addr | input | 32 | Byte address of the window start |
| fetch_rdy | output | 1 | Block is idle and will accept a request |
| p0_index | output | 7 | Set index for port 0 |
| p0_half | output | 1 | Half select for port 0 (1 = upper 16 bytes) |
| p0_tag | input | 20 | Stored tag returned on port 0 |
| p0_coh | input | 2 | Coherence code returned on port 0 |
| p0_data | input | 128 | Half-line data on port 0, lowest address in bits 7:0 |
| p0_par | input | 2 | Parity bits of the two 8-byte groups on port 0 |
| p1_index | output | 7 | Set index for port 1 |
| p1_half | output | 1 | Half select for port 1 |
| p1_tag | input | 20 | Stored tag returned on port 1 |
| p1_coh | input | 2 | Coherence code returned on port 1 |
| p1_data | input | 128 | Half-line data on port 1 |
| p1_par | input | 2 | Parity bits on port 1 |
| fetch_done | output | 1 | Result cycle strobe |
| win_vld | output | 1 | Window is valid (both ports hit, parity clean) |
| win_data | output | 128 | Aligned window, byte i at bits 8i+7:8i |
| miss0 | output | 1 | Port 0 missed |
| miss1 | output | 1 | Port 1 missed |
| miss_line | output | 27 | Line address of the first missing port |
| par_err | output | 1 | Parity mismatch seen |

## Verification
The assertions assume that the array answers within the LOOKUP cycle: for the index and half the block drives, the array settles tag, coherence, data and parity before the capture edge. They also assume that the requester holds a request only while it waits for `fetch_rdy`.

The bench models the array as a combinational lookup of its own tables, so every response belongs to the address being driven. It drops the request in the RESP cycle. It holds the request high, with a changed address, only during LOOKUP, to show that the block ignores it. Tags come from a small pool so that hits and misses both occur often. Coherence codes and parity bits are corrupted at controlled rates.

// File: rtl/sla_pkg.sv
package sla_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_RESP   = 2'd2
    } fsm_t;

    localparam logic [1:0] COH_INV = 2'b00;
    localparam logic [1:0] COH_SHR = 2'b01;
endpackage

// File: rtl/sla_addr_split.sv
module sla_addr_split #(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 32,
    parameter int IDX_W      = 7,
    localparam int HB_W      = $clog2(LINE_BYTES / 2),
    localparam int HAW       = AW - HB_W,
    localparam int LAW       = HAW - 1,
    localparam int TAG_W     = LAW - IDX_W
) (
    input  logic [AW-1:0]    addr,
    output logic [IDX_W-1:0] idx0,
    output logic             half0,
    output logic [TAG_W-1:0] tag0,
    output logic [LAW-1:0]   line0,
    output logic [IDX_W-1:0] idx1,
    output logic             half1,
    output logic [TAG_W-1:0] tag1,
    output logic [LAW-1:0]   line1
);
    logic [HAW-1:0] h0, h1;

    assign h0    = addr[AW-1:HB_W];
    assign h1    = h0 + 1'b1;
    assign half0 = h0[0];
    assign half1 = h1[0];
    assign line0 = h0[HAW-1:1];
    assign line1 = h1[HAW-1:1];
    assign idx0  = line0[IDX_W-1:0];
    assign idx1  = line1[IDX_W-1:0];
    assign tag0  = line0[LAW-1:IDX_W];
    assign tag1  = line1[LAW-1:IDX_W];
endmodule

// File: rtl/sla_par_chk.sv
module sla_par_chk #(
    parameter int HALF_BYTES = 16,
    parameter int GRP_BYTES  = 8,
    localparam int NG        = HALF_BYTES / GRP_BYTES
) (
    input  logic [HALF_BYTES*8-1:0] data,
    input  logic [NG-1:0]           par,
    output logic                    bad
);
    logic [NG-1:0] grp_bad;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign grp_bad[g] = (^data[g*GRP_BYTES*8 +: GRP_BYTES*8]) != par[g];
    end

    assign bad = |grp_bad;
endmodule

// File: rtl/sla_rotator.sv
module sla_rotator #(
    parameter int HALF_BYTES = 16,
    localparam int SH_W      = $clog2(HALF_BYTES)
) (
    input  logic [HALF_BYTES*8-1:0] lo,
    input  logic [HALF_BYTES*8-1:0] hi,
    input  logic [SH_W-1:0]         sh,
    output logic [HALF_BYTES*8-1:0] win
);
    logic [2*HALF_BYTES*8-1:0] joined;
    assign joined = {hi, lo};

    for (genvar i = 0; i < HALF_BYTES; i++) begin : g_byte
        logic [SH_W:0] src;
        assign src = {1'b0, sh} + (SH_W+1)'(i);
        assign win[8*i +: 8] = joined[8*src +: 8];
    end
endmodule

// File: rtl/sla_fetch_aligner.sv
module sla_fetch_aligner
    import sla_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 32,
    parameter int SETS       = 128,
    parameter int GRP_BYTES  = 8,
    localparam int HALF_BYTES = LINE_BYTES / 2,
    localparam int HB_W       = $clog2(HALF_BYTES),
    localparam int IDX_W      = $clog2(SETS),
    localparam int LAW        = AW - $clog2(LINE_BYTES),
    localparam int TAG_W      = LAW - IDX_W,
    localparam int NG         = HALF_BYTES / GRP_BYTES,
    localparam int DW         = HALF_BYTES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_req,
    input  logic [AW-1:0]    fetch_addr,
    output logic             fetch_rdy,
    output logic [IDX_W-1:0] p0_index,
    output logic             p0_half,
    input  logic [TAG_W-1:0] p0_tag,
    input  logic [1:0]       p0_coh,
    input  logic [DW-1:0]    p0_data,
    input  logic [NG-1:0]    p0_par,
    output logic [IDX_W-1:0] p1_index,
    output logic             p1_half,
    input  logic [TAG_W-1:0] p1_tag,
    input  logic [1:0]       p1_coh,
    input  logic [DW-1:0]    p1_data,
    input  logic [NG-1:0]    p1_par,
    output logic             fetch_done,
    output logic             win_vld,
    output logic [DW-1:0]    win_data,
    output logic             miss0,
    output logic             miss1,
    output logic [LAW-1:0]   miss_line,
    output logic             par_err
);
    fsm_t            state_q, state_d;
    logic [AW-1:0]   addr_q;
    logic [TAG_W-1:0] tag0, tag1;
    logic [LAW-1:0]  line0, line1;
    logic            hit0, hit1, bad0, bad1;
    logic [DW-1:0]   rot_win;

    logic            m0_q, m1_q, err_q;
    logic [LAW-1:0]  ml_q;
    logic [DW-1:0]   win_q;

    sla_addr_split #(.AW(AW), .LINE_BYTES(LINE_BYTES), .IDX_W(IDX_W)) u_split (
        .addr(addr_q),
        .idx0(p0_index), .half0(p0_half), .tag0(tag0), .line0(line0),
        .idx1(p1_index), .half1(p1_half), .tag1(tag1), .line1(line1)
    );

    sla_par_chk #(.HALF_BYTES(HALF_BYTES), .GRP_BYTES(GRP_BYTES)) u_par0 (
        .data(p0_data), .par(p0_par), .bad(bad0)
    );

    sla_par_chk #(.HALF_BYTES(HALF_BYTES), .GRP_BYTES(GRP_BYTES)) u_par1 (
        .data(p1_data), .par(p1_par), .bad(bad1)
    );

    sla_rotator #(.HALF_BYTES(HALF_BYTES)) u_rot (
        .lo(p0_data), .hi(p1_data), .sh(addr_q[HB_W-1:0]), .win(rot_win)
    );

    assign hit0 = (p0_coh == COH_SHR) && (p0_tag == tag0);
    assign hit1 = (p1_coh == COH_SHR) && (p1_tag == tag1);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (fetch_req) state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = ST_RESP;
            ST_RESP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and captured lookup result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            m0_q    <= 1'b0;
            m1_q    <= 1'b0;
            err_q   <= 1'b0;
            ml_q    <= '0;
            win_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && fetch_req) addr_q <= fetch_addr;
            if (state_q == ST_LOOKUP) begin
                m0_q  <= !hit0;
                m1_q  <= !hit1;
                err_q <= hit0 && hit1 && (bad0 || bad1);
                ml_q  <= !hit0 ? line0 : (!hit1 ? line1 : '0);
                win_q <= rot_win;
            end
        end
    end

    // outputs
    always_comb begin
        fetch_rdy  = 1'b0;
        fetch_done = 1'b0;
        win_vld    = 1'b0;
        miss0      = 1'b0;
        miss1      = 1'b0;
        par_err    = 1'b0;
        miss_line  = '0;
        win_data   = win_q;
        unique case (state_q)
            ST_IDLE:   fetch_rdy = 1'b1;
            ST_LOOKUP: ;
            ST_RESP: begin
                fetch_done = 1'b1;
                miss0      = m0_q;
                miss1      = m1_q;
                par_err    = err_q;
                miss_line  = ml_q;
                win_vld    = !m0_q && !m1_q && !err_q;
            end
            default: ;
        endcase
    end

    // R2
    port_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP) |-> ({p1_index, p1_half} == {p0_index, p0_half} + 1'b1));

    // R4
    done_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_rdy) |=> ##1 fetch_done);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |=> !fetch_done);

    // R6
    miss_novld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss0 || miss1) |-> (!win_vld && fetch_done));

    // R7
    perr_novld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> !win_vld);

    // R8
    busy_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |-> !fetch_rdy);

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP) |=> $stable(addr_q));
endmodule

// File: tb/sim_sla_fetch_aligner.sv
`timescale 1ns/1ps
module sim_sla_fetch_aligner;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic         fetch_req;
    logic [31:0]  fetch_addr;
    logic         fetch_rdy;
    logic [6:0]   p0_index, p1_index;
    logic         p0_half, p1_half;
    logic [19:0]  p0_tag, p1_tag;
    logic [1:0]   p0_coh, p1_coh;
    logic [127:0] p0_data, p1_data;
    logic [1:0]   p0_par, p1_par;
    logic         fetch_done, win_vld, miss0, miss1, par_err;
    logic [127:0] win_data;
    logic [26:0]  miss_line;

    sla_fetch_aligner u0 (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_rdy(fetch_rdy),
        .p0_index(p0_index), .p0_half(p0_half), .p0_tag(p0_tag), .p0_coh(p0_coh),
        .p0_data(p0_data), .p0_par(p0_par),
        .p1_index(p1_index), .p1_half(p1_half), .p1_tag(p1_tag), .p1_coh(p1_coh),
        .p1_data(p1_data), .p1_par(p1_par),
        .fetch_done(fetch_done), .win_vld(win_vld), .win_data(win_data),
        .miss0(miss0), .miss1(miss1), .miss_line(miss_line), .par_err(par_err)
    );

    // array model
    logic [19:0] b_tag [128];
    logic [1:0]  b_coh [128];
    logic [7:0]  b_mem [128][32];
    logic [3:0]  b_par [128];

    always_comb begin
        p0_tag = b_tag[p0_index];
        p0_coh = b_coh[p0_index];
        p0_par = b_par[p0_index][2*p0_half +: 2];
        p1_tag = b_tag[p1_index];
        p1_coh = b_coh[p1_index];
        p1_par = b_par[p1_index][2*p1_half +: 2];
        for (int i = 0; i < 16; i++) begin
            p0_data[8*i +: 8] = b_mem[p0_index][16*p0_half + i];
            p1_data[8*i +: 8] = b_mem[p1_index][16*p1_half + i];
        end
    end

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic line_hit(input logic [26:0] l);
        return (b_coh[l[6:0]] == 2'b01) && (b_tag[l[6:0]] == l[26:7]);
    endfunction

    function automatic logic [7:0] byte_at(input logic [31:0] a);
        return b_mem[a[11:5]][a[4:0]];
    endfunction

    function automatic logic half_bad(input logic [27:0] h);
        logic bad = 1'b0;
        for (int g = 0; g < 2; g++) begin
            logic x = 1'b0;
            for (int b = 0; b < 8; b++) x ^= ^b_mem[h[7:1]][16*h[0] + 8*g + b];
            if (x != b_par[h[7:1]][2*h[0] + g]) bad = 1'b1;
        end
        return bad;
    endfunction

    function automatic logic [3:0] good_par(input int idx);
        logic [3:0] p;
        for (int g = 0; g < 4; g++) begin
            p[g] = 1'b0;
            for (int b = 0; b < 8; b++) p[g] ^= ^b_mem[idx][8*g + b];
        end
        return p;
    endfunction

    task automatic run_fetch(input logic [31:0] a, input bit hold_req);
        logic [26:0]  l0, l1;
        logic [27:0]  h0;
        logic         e0, e1, eerr;
        logic [127:0] ew;
        h0 = a[31:4];
        l0 = a[31:5];
        l1 = 27'((h0 + 28'd1) >> 1);
        e0 = !line_hit(l0);
        e1 = !line_hit(l1);
        eerr = !e0 && !e1 && (half_bad(h0) || half_bad(h0 + 28'd1));
        for (int i = 0; i < 16; i++) ew[8*i +: 8] = byte_at(a + 32'(i));

        @(negedge clk);
        fetch_req  = 1'b1;
        fetch_addr = a;
        @(negedge clk);
        chk("R4 no early done", {127'd0, fetch_done}, 128'd0);
        if (hold_req) begin
            chk("R8 rdy low in lookup", {127'd0, fetch_rdy}, 128'd0);
            fetch_addr = ~a;
        end else begin
            fetch_req = 1'b0;
        end
        @(negedge clk);
        fetch_req = 1'b0;
        chk("R4 done", {127'd0, fetch_done}, 128'd1);
        chk("R8 rdy low in result", {127'd0, fetch_rdy}, 128'd0);
        chk("R5 R6 miss0", {127'd0, miss0}, {127'd0, e0});
        chk("R5 R6 miss1", {127'd0, miss1}, {127'd0, e1});
        chk("R6 miss_line", {101'd0, miss_line}, {101'd0, e0 ? l0 : (e1 ? l1 : 27'd0)});
        chk("R7 par_err", {127'd0, par_err}, {127'd0, eerr});
        chk("R6 R7 win_vld", {127'd0, win_vld}, {127'd0, !e0 && !e1 && !eerr});
        if (!e0 && !e1) chk("R2 R3 window", win_data, ew);
        @(negedge clk);
        chk("R4 single pulse", {127'd0, fetch_done}, 128'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        fetch_req  = 1'b0;
        fetch_addr = '0;
        for (int s = 0; s < 128; s++) begin
            b_tag[s] = 20'($urandom_range(0, 3));
            b_coh[s] = 2'b01;
            for (int b = 0; b < 32; b++) b_mem[s][b] = 8'($urandom);
            b_par[s] = good_par(s);
        end
        repeat (3) @(negedge clk);
        chk("R1 rdy", {127'd0, fetch_rdy}, 128'd1);
        chk("R1 idle outs", {123'd0, fetch_done, win_vld, miss0, miss1, par_err}, 128'd0);
        rst_n = 1'b1;

        // directed: same-line aligned, boundary-straddle, last byte, index wrap
        b_tag[5] = 20'd2; b_tag[6] = 20'd2;
        run_fetch({20'd2, 7'd5, 5'd0}, 1'b0);
        run_fetch({20'd2, 7'd5, 5'd16}, 1'b0);
        run_fetch({20'd2, 7'd5, 5'd31}, 1'b0);
        run_fetch({20'd2, 7'd5, 5'd9}, 1'b1);
        b_tag[127] = 20'd1; b_tag[0] = 20'd2;
        run_fetch({20'd1, 7'd127, 5'd20}, 1'b0);
        // R5: invalid and unknown coherence codes miss
        b_coh[6] = 2'b00;
        run_fetch({20'd2, 7'd5, 5'd24}, 1'b0);
        b_coh[6] = 2'b11;
        run_fetch({20'd2, 7'd5, 5'd24}, 1'b0);
        b_coh[5] = 2'b10;
        run_fetch({20'd2, 7'd5, 5'd24}, 1'b0);
        b_coh[5] = 2'b01; b_coh[6] = 2'b01;
        // R7: parity corruption on second port
        b_par[6][0] = ~b_par[6][0];
        run_fetch({20'd2, 7'd5, 5'd17}, 1'b0);
        b_par[6] = good_par(6);

        // random
        for (int n = 0; n < 400; n++) begin
            int s = $urandom_range(0, 127);
            int r = $urandom_range(0, 15);
            if (r == 0) b_coh[s] = 2'b00;
            else if (r == 1) b_coh[s] = 2'($urandom_range(2, 3));
            else b_coh[s] = 2'b01;
            b_par[s] = good_par(s);
            if ($urandom_range(0, 15) == 0) b_par[s][$urandom_range(0, 3)] ^= 1'b1;
            run_fetch({20'($urandom_range(0, 3)), 7'($urandom_range(0, 127)), 5'($urandom_range(0, 31))},
                      bit'($urandom_range(0, 1)));
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 200000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<200000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule